// File: doc/BRIEF.md
# Packed Integer Add/Subtract Unit

This block is a 128-bit packed integer arithmetic unit. It splits two operands into independent lanes of 8, 16, 32 or 64 bits and performs the same operation on every lane at once: modular add or subtract, add or subtract clipped to signed or unsigned lane limits, an unsigned average rounded upward, or a byte-wise sum of absolute differences. No carry or borrow ever crosses from one lane into the next.

A request is presented with `in_valid` together with an opcode, a lane size, a half-width flag and the two operands. One clock later the result appears on `out_data` with `out_valid` high. Subtraction is always first operand (`opnd_d`) minus second operand (`opnd_s`). When the half-width flag is set only the low 64 bits carry a result and the high 64 bits read zero. Opcode and lane-size pairs that the unit does not support produce an all-zero result.

Top module: `packed_addsub_unit`

## Requirements
- R1: After reset `out_valid` and `out_data` are 0; a request with `in_valid` high produces its result on `out_data` and `out_valid` high one clock later, and with `in_valid` low `out_valid` falls and `out_data` keeps its previous value.
- R2: Opcode 0 adds and opcode 1 subtracts (`opnd_d` minus `opnd_s`) modulo 2^lane-width in every lane, for lane size code 0 (8 bit), 1 (16 bit), 2 (32 bit) and 3 (64 bit); lane i occupies bits [i*W+W-1 : i*W] and no carry or borrow reaches a neighbouring lane.
- R3: Opcode 2 adds and opcode 3 subtracts with signed saturation for 8-bit and 16-bit lanes, clipping to -128..127 or -32768..32767 (for example 0x7F+0x7F gives 0x7F and 0x80+0x80 gives 0x80).
- R4: Opcode 4 adds and opcode 5 subtracts with unsigned saturation for 8-bit and 16-bit lanes, clipping sums above 255 or 65535 to the maximum and any negative difference to zero.
- R5: Opcode 6 returns (d + s + 1) >> 1 per unsigned 8-bit or 16-bit lane, computed without loss of the carry.
- R6: Opcode 7 with 8-bit lanes returns, for each 64-bit half, the sum of the eight byte-wise absolute differences in bits [15:0] of that half, with bits [63:16] of the half cleared.
- R7: Opcodes 2 to 6 with lane size code 2 or 3, and opcode 7 with any lane size code other than 0, give an all-zero result.
- R8: With `half_only` high, bits [127:64] of the result are zero and bits [63:0] are as in full-width mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Opcode 0..7 |
| lane_sz | input | 2 | Lane size code: 0=8, 1=16, 2=32, 3=64 bits |
| half_only | input | 1 | Use only the low 64 bits |
| opnd_d | input | 128 | First operand (minuend) |
| opnd_s | input | 128 | Second operand (subtrahend) |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_data | output | 128 | Registered result |

## Verification
Half-width mode and the sum of absolute differences can meet in one request: the SAD writes a sum into the upper half while the half-width flag must erase it. The bench provokes this by issuing SAD and every other opcode with `half_only` high on random operands, and judges it against a model that first computes all lanes and then blanks the upper 64 bits. Lane isolation is judged by an exhaustive byte sweep, in which neighbouring lanes carry unrelated pairs so that any leaked carry shows as a mismatch.

// File: rtl/packed_addsub_unit.sv
module packed_addsub_unit #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    op_sel,
  input  logic [1:0]    lane_sz,
  input  logic          half_only,
  input  logic [DW-1:0] opnd_d,
  input  logic [DW-1:0] opnd_s,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  localparam int HW = DW / 2;
  localparam int NB = HW / 8;

  logic [3:0][DW-1:0] add_w, sub_w;
  logic [1:0][DW-1:0] sadd_s, ssub_s, sadd_u, ssub_u, avg_u;
  logic [DW-1:0] sad_v, nxt;
  logic [10:0] acc;
  logic [7:0] bx, by;
  logic ok;

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int LW = 8 << s;
    localparam int NL = DW / LW;
    for (genvar j = 0; j < NL; j++) begin : g_ln
      logic [LW-1:0] a, b;
      assign a = opnd_d[j*LW +: LW];
      assign b = opnd_s[j*LW +: LW];
      assign add_w[s][j*LW +: LW] = a + b;
      assign sub_w[s][j*LW +: LW] = a - b;
      if (s < 2) begin : g_sat
        localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
        localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
        logic [LW:0] us, ud, ss, sd, ap;
        assign us = {1'b0, a} + {1'b0, b};
        assign ud = {1'b0, a} - {1'b0, b};
        assign ss = {a[LW-1], a} + {b[LW-1], b};
        assign sd = {a[LW-1], a} - {b[LW-1], b};
        assign ap = us + {{LW{1'b0}}, 1'b1};
        assign sadd_s[s][j*LW +: LW] = (ss[LW] ^ ss[LW-1]) ? (ss[LW] ? SMIN : SMAX) : ss[LW-1:0];
        assign ssub_s[s][j*LW +: LW] = (sd[LW] ^ sd[LW-1]) ? (sd[LW] ? SMIN : SMAX) : sd[LW-1:0];
        assign sadd_u[s][j*LW +: LW] = us[LW] ? {LW{1'b1}} : us[LW-1:0];
        assign ssub_u[s][j*LW +: LW] = ud[LW] ? {LW{1'b0}} : ud[LW-1:0];
        assign avg_u[s][j*LW +: LW]  = ap[LW:1];
      end
    end
  end

  always_comb begin
    sad_v = '0;
    acc = '0;
    bx = '0;
    by = '0;
    for (int h = 0; h < 2; h++) begin
      acc = '0;
      for (int k = 0; k < NB; k++) begin
        bx = opnd_d[h*HW + k*8 +: 8];
        by = opnd_s[h*HW + k*8 +: 8];
        acc = acc + {3'b000, (bx > by) ? (bx - by) : (by - bx)};
      end
      sad_v[h*HW +: 11] = acc;
    end
  end

  assign ok = (op_sel < 3'd2) || ((op_sel == 3'd7) ? (lane_sz == 2'd0) : !lane_sz[1]);

  always_comb begin
    case (op_sel)
      3'd0: nxt = add_w[lane_sz];
      3'd1: nxt = sub_w[lane_sz];
      3'd2: nxt = sadd_s[lane_sz[0]];
      3'd3: nxt = ssub_s[lane_sz[0]];
      3'd4: nxt = sadd_u[lane_sz[0]];
      3'd5: nxt = ssub_u[lane_sz[0]];
      3'd6: nxt = avg_u[lane_sz[0]];
      default: nxt = sad_v;
    endcase
    if (!ok) nxt = '0;
    if (half_only) nxt[DW-1:HW] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end

  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));
  a_r4_usat_add_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd4 && lane_sz == 2'd0) |=> out_data[7:0] >= $past(opnd_d[7:0]));
  a_r4_usat_sub_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd5 && lane_sz == 2'd0) |=> out_data[7:0] <= $past(opnd_d[7:0]));
  a_r6_sad_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'd7 && lane_sz == 2'd0) |=> (out_data[HW-1:16] == '0 && out_data[DW-1:HW+16] == '0));
  a_r7_unsupported_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ((op_sel >= 3'd2 && op_sel <= 3'd6 && lane_sz[1]) || (op_sel == 3'd7 && lane_sz != 2'd0))) |=> out_data == '0);
  a_r8_half_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && half_only) |=> out_data[DW-1:HW] == '0);
endmodule

// File: tb/packed_addsub_unit_test.sv
`timescale 1ns/1ps
module packed_addsub_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [2:0] op_sel = '0;
  logic [1:0] lane_sz = '0;
  logic half_only = 1'b0;
  logic [127:0] opnd_d = '0, opnd_s = '0;
  logic out_valid;
  logic [127:0] out_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  packed_addsub_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .lane_sz(lane_sz),
    .half_only(half_only), .opnd_d(opnd_d), .opnd_s(opnd_s),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [127:0] model(input logic [2:0] op, input logic [1:0] sz,
                                         input logic nar, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    logic [63:0] m, va, vb, v;
    int lw, t, sa, sb, hi, lo;
    r = '0;
    lw = 8 << sz;
    if ((op >= 2 && op <= 6 && sz >= 2) || (op == 7 && sz != 0)) return '0;
    if (op == 7) begin
      for (int h = 0; h < 2; h++) begin
        t = 0;
        for (int k = 0; k < 8; k++) begin
          sa = int'(a[h*64 + k*8 +: 8]);
          sb = int'(b[h*64 + k*8 +: 8]);
          t += (sa > sb) ? sa - sb : sb - sa;
        end
        r[h*64 +: 16] = 16'(t);
      end
    end else begin
      m = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
      for (int l = 0; l < 128 / lw; l++) begin
        va = 64'(a >> (l*lw)) & m;
        vb = 64'(b >> (l*lw)) & m;
        v = '0;
        case (op)
          3'd0: v = va + vb;
          3'd1: v = va - vb;
          3'd2, 3'd3: begin
            sa = int'(va); sb = int'(vb);
            if (va[lw-1]) sa -= (1 << lw);
            if (vb[lw-1]) sb -= (1 << lw);
            t = (op == 3'd2) ? sa + sb : sa - sb;
            hi = (1 << (lw-1)) - 1; lo = -(1 << (lw-1));
            if (t > hi) t = hi;
            if (t < lo) t = lo;
            v = 64'(longint'(t));
          end
          3'd4, 3'd5: begin
            t = (op == 3'd4) ? int'(va) + int'(vb) : int'(va) - int'(vb);
            if (t > (1 << lw) - 1) t = (1 << lw) - 1;
            if (t < 0) t = 0;
            v = 64'(t);
          end
          default: v = (va + vb + 64'd1) >> 1;
        endcase
        r = r | (128'(v & m) << (l*lw));
      end
    end
    if (nar) r[127:64] = '0;
    return r;
  endfunction

  function automatic string tag(input logic [2:0] op, input logic [1:0] sz, input logic nar);
    if (nar) return "R8";
    if ((op >= 2 && op <= 6 && sz >= 2) || (op == 7 && sz != 0)) return "R7";
    case (op)
      3'd0, 3'd1: return "R2";
      3'd2, 3'd3: return "R3";
      3'd4, 3'd5: return "R4";
      3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run(input logic [2:0] op, input logic [1:0] sz, input logic nar,
                     input logic [127:0] a, input logic [127:0] b);
    logic [127:0] exp;
    exp = model(op, sz, nar, a, b);
    op_sel = op; lane_sz = sz; half_only = nar; opnd_d = a; opnd_s = b; in_valid = 1'b1;
    @(negedge clk);
    checks++;
    if (!out_valid || out_data !== exp) begin
      fails++;
      $display("FAIL %s op=%0d sz=%0d: got v=%0b %h expected v=1 %h", tag(op, sz, nar), op, sz, out_valid, out_data, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] a, b, held;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b %h expected v=0 0", out_valid, out_data);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7: every byte pair in every 8-bit opcode
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 4096; k++) begin
        for (int j = 0; j < 16; j++) begin
          a[j*8 +: 8] = 8'((k*16 + j) >> 8);
          b[j*8 +: 8] = 8'(k*16 + j);
        end
        run(3'(op), 2'd0, 1'b0, a, b);
      end
    end

    // wider lanes, random and boundary operands
    for (int sz = 1; sz < 4; sz++) begin
      for (int op = 0; op < 8; op++) begin
        for (int n = 0; n < 300; n++) begin
          a = rnd128(); b = rnd128();
          if (n % 4 == 1) begin a = {16{8'h7F}} | (rnd128() & {16{8'h0F}}); b = a; end
          if (n % 4 == 2) begin a = {16{8'h80}}; b = {16{8'h80}} | (rnd128() & {16{8'h01}}); end
          if (n % 4 == 3) begin a = '1; b = rnd128() | {8{16'h8001}}; end
          run(3'(op), 2'(sz), 1'b0, a, b);
        end
      end
    end

    // R8: half-width with every opcode and size, including SAD
    for (int n = 0; n < 1000; n++)
      run(3'(n % 8), 2'((n / 8) % 4), 1'b1, rnd128(), rnd128());

    // R1: idle cycles hold the result
    run(3'd0, 2'd0, 1'b0, 128'h1, 128'h2);
    held = out_data;
    in_valid = 1'b0; opnd_d = rnd128(); opnd_s = rnd128(); op_sel = 3'd1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== held) begin
      fails++;
      $display("FAIL R1 hold: got v=%0b %h expected v=0 %h", out_valid, out_data, held);
    end

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog: got no completion expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule